// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands over several clock cycles rather than in one combinational pass. A one-cycle pulse on `start_i` wakes a small controller. The controller copies both operands into internal registers. It then walks through the multiplier one bit at a time. For each bit it either adds the multiplicand into a running accumulator and shifts, or only shifts. When all bits have been consumed, it publishes the product and raises a one-cycle completion flag.

The operand width is a parameter, `W`, with a default of 8, which gives a 16-bit product. Only one operation is in flight at a time. A request that arrives while an operation is running is dropped. The product register keeps the last result until the next completion.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `stop_o` is 0 and `product_o` is 0.
- R2: In the idle state, with `start_i` held at 0, the block stays idle and `stop_o` stays 0 for any number of cycles.
- R3: When an operation completes, `product_o` equals the unsigned product `mcand_i * mplier_i`, 2W bits wide, with no truncation, for all operand values including 0, 1 and 2^W-1.
- R4: Count the rising edge that samples `start_i`=1 in idle as edge 0. Then `stop_o` is high exactly after edge 1 + 2·W + ones(b), where ones(b) is the number of 1 bits in the multiplier operand. Each multiplier bit costs a test cycle and a shift cycle, plus one add cycle when the bit is 1.
- R5: `stop_o` is high for exactly one cycle per completed operation.
- R6: `product_o` changes only in the cycle in which `stop_o` is high, and holds its value otherwise.
- R7: A `start_i` pulse while an operation runs is ignored. It neither alters the running result nor produces an extra completion.
- R8: Operands are captured on edge 1, the edge after the one that accepts `start_i`. Later changes on `mcand_i` and `mplier_i` do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, honoured only when idle |
| mcand_i | input | W | Multiplicand operand, unsigned |
| mplier_i | input | W | Multiplier operand, unsigned |
| product_o | output | 2W | Registered product of the last completed operation |
| stop_o | output | 1 | One-cycle completion flag |

## Verification
Each kind of internal fault shows at the ports in its own way:

- **Adder or shift fault:** a corrupted accumulator or shift register gives a wrong `product_o` at the very next completion. Operands with isolated, dense and boundary bit patterns make sure every carry position is reached.
- **Control fault:** a slip in the controller, such as a skipped add, an extra shift or a miscounted step, moves the `stop_o` edge away from the cycle predicted by R4. The bench therefore times every operation, not only its result.
- **Busy-state fault:** a controller that re-enters its load state while busy shows within one operation, either as an extra `stop_o` pulse or as a product computed from the intruding operands.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_TEST  = 3'd2,
    ST_ADD   = 3'd3,
    ST_SHIFT = 3'd4
  } mul_state_e;

  function automatic int unsigned cnt_width(input int unsigned w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/sam_ripple_adder.sv
module sam_ripple_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[W];

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shift_add_mult_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = cnt_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          lsb_i,
  output logic          load_o,
  output logic          add_o,
  output logic          shift_o,
  output logic          last_o,
  output logic          stop_o,
  output mul_state_e    state_o,
  output logic [CW-1:0] cnt_o
);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          stop_q;
  logic          last_step;

  assign last_step = (cnt_q == CW'(W - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_INIT;
      ST_INIT:  state_d = ST_TEST;
      ST_TEST:  state_d = lsb_i ? ST_ADD : ST_SHIFT;
      ST_ADD:   state_d = ST_SHIFT;
      ST_SHIFT: state_d = last_step ? ST_IDLE : ST_TEST;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= last_o;
      if (state_q == ST_INIT) cnt_q <= '0;
      else if (state_q == ST_SHIFT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign load_o  = (state_q == ST_INIT);
  assign add_o   = (state_q == ST_ADD);
  assign shift_o = (state_q == ST_SHIFT);
  assign last_o  = shift_o & last_step;
  assign stop_o  = stop_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  input  logic          load_i,
  input  logic          add_i,
  input  logic          shift_i,
  input  logic          last_i,
  output logic          lsb_o,
  output logic [PW-1:0] product_o
);

  logic [W-1:0]  mcand_q;
  logic [W:0]    acc_q;     // one spare bit holds the add carry
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] prod_q;
  logic [W-1:0]  sum;
  logic          cout;
  logic [PW:0]   shifted;

  sam_ripple_adder #(.W(W)) adder_i (
    .a_i   (acc_q[W-1:0]),
    .b_i   (mcand_q),
    .sum_o (sum),
    .cout_o(cout)
  );

  assign shifted = {1'b0, acc_q, mplier_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else begin
      if (load_i) begin
        mcand_q  <= mcand_i;
        mplier_q <= mplier_i;
        acc_q    <= '0;
      end else if (add_i) begin
        acc_q <= {cout, sum};
      end else if (shift_i) begin
        {acc_q, mplier_q} <= shifted;
        if (last_i) prod_q <= shifted[PW-1:0];
      end
    end
  end

  assign lsb_o     = mplier_q[0];
  assign product_o = prod_q;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shift_add_mult_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned CW = cnt_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic [PW-1:0] product_o,
  output logic          stop_o
);

  logic          load, add, shift, last, lsb;
  mul_state_e    state;
  logic [CW-1:0] cnt;

  sam_ctrl #(.W(W)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .lsb_i  (lsb),
    .load_o (load),
    .add_o  (add),
    .shift_o(shift),
    .last_o (last),
    .stop_o (stop_o),
    .state_o(state),
    .cnt_o  (cnt)
  );

  sam_datapath #(.W(W)) dp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .load_i   (load),
    .add_i    (add),
    .shift_i  (shift),
    .last_i   (last),
    .lsb_o    (lsb),
    .product_o(product_o)
  );

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk
  import shift_add_mult_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned CW = cnt_width(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_o,
  input logic [PW-1:0] product_o,
  input mul_state_e    state,
  input logic [CW-1:0] cnt
);

  // R5
  stop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);

  // R6
  product_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_o |-> $stable(product_o));

  // R2
  idle_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !start_i) |=> (state == ST_IDLE && !stop_o));

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |=> (state != ST_INIT));

  // R4
  stop_in_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (state == ST_IDLE));

  // R4
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(W));

endmodule

bind shift_add_mult shift_add_mult_chk #(.W(W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .stop_o   (stop_o),
  .product_o(product_o),
  .state    (state),
  .cnt      (cnt)
);

// File: tb/shift_add_mult_tb_top.sv
module shift_add_mult_tb_top;

  localparam int unsigned W  = 8;
  localparam int unsigned PW = 2 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  mcand_i = '0;
  logic [W-1:0]  mplier_i = '0;
  logic [PW-1:0] product_o;
  logic          stop_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  shift_add_mult #(.W(W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o),
    .stop_o   (stop_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input int k);
    if (k < 17) return W'(k * 15);
    if (k == 17) return W'(1);
    if (k == 18) return W'(255);
    return W'(128);
  endfunction

  // One operation. Optional intruding start while busy (R7).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    int n;
    logic [PW-1:0] exp_p;
    int exp_n;
    int stops;
    exp_p = PW'(a) * PW'(b);
    exp_n = 2 + 2 * W + $countones(b);
    @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk_i);
    n = 1;
    start_i = 1'b0;
    @(negedge clk_i);
    n++;
    mcand_i = ~a; mplier_i = b ^ 8'h5a; // R8: inputs change after capture
    if (intrude) begin
      @(negedge clk_i);
      n++;
      start_i = 1'b1; mcand_i = 8'd7; mplier_i = 8'd9;
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
    end
    while (!stop_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check(stop_o == 1'b1, "R4 stop seen", longint'(stop_o), 1);
    check(n == exp_n, "R4 latency", n, exp_n);
    check(product_o == exp_p, intrude ? "R7 product" : "R3 R8 product", product_o, exp_p);
    @(negedge clk_i);
    check(stop_o == 1'b0, "R5 stop width", longint'(stop_o), 0);
    check(product_o == exp_p, "R6 product hold", product_o, exp_p);
    if (intrude) begin
      stops = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        if (stop_o) stops++;
      end
      check(stops == 0, "R7 no extra stop", stops, 0);
      check(product_o == exp_p, "R7 product kept", product_o, exp_p);
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int stops;
    #3;
    check(stop_o == 1'b0, "R1 stop in reset", longint'(stop_o), 0);
    check(product_o == '0, "R1 product in reset", product_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(stop_o == 1'b0, "R1 stop after reset", longint'(stop_o), 0);
    check(product_o == '0, "R1 product after reset", product_o, 0);

    // R2: idle with operands moving, no start
    stops = 0;
    for (int i = 0; i < 20; i++) begin
      mcand_i = W'(i * 13); mplier_i = W'(i * 7 + 1);
      @(negedge clk_i);
      if (stop_o) stops++;
    end
    check(stops == 0, "R2 idle no stop", stops, 0);
    check(product_o == '0, "R2 idle product", product_o, 0);

    // R3: structured sweep including 0, 1, 128, 255
    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++)
        run_op(pick(i), pick(j), 1'b0);

    // R3: random operands
    for (int k = 0; k < 300; k++)
      run_op(W'($urandom_range(0, 255)), W'($urandom_range(0, 255)), 1'b0);

    // R7: start while busy
    run_op(8'd200, 8'd13, 1'b1);
    run_op(8'd255, 8'd255, 1'b1);
    run_op(8'd0, 8'd0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule